// File: doc/BRIEF.md
# CAN Receive Mailbox Filter

This block sits behind a CAN protocol engine that has already turned bus bits into whole frames. Each frame arrives as a descriptor: identifier, format flag (standard or extended), remote-request flag, length code and up to eight data bytes. The block decides which of its mailboxes, if any, should keep the frame. It writes that frame to mailbox storage through a one-cycle strobe and keeps per-mailbox receive-pending, message-lost and remote-pending flags. A remote request that matches a transmit mailbox is not stored. Instead, that mailbox is marked and the transmit side is told, through a reply request, which mailbox should answer.

Configuration and status live in 32-bit words with one bit per mailbox, reached through a simple word-wide register port. Per-mailbox identifier and mask words sit in two 32-word windows. A controller flow of three states handles each frame:
- IDLE: ready for a frame. Moves to MATCH on an accepted descriptor.
- MATCH: compares the held frame against every mailbox and registers the hit vectors. Always moves to DECIDE.
- DECIDE: picks the target, drives the strobe or the reply request, and updates the flags. Always returns to IDLE.

Top module: `can_rx_filter`

## Requirements
- R1: After reset every pending, lost and remote-pending bit is 0, `frm_ready` is 1, and neither `st_wr` nor `reply_req` is asserted.
- R2: A frame matches a mailbox only when all four hold: the mailbox's enable bit (word 0) is 1, its direction bit (word 1, 1 = receive) is 1, its format bit (word 3, 1 = extended) equals `frm_ide`, and the identifiers agree on every unmasked compared bit. A matching frame is offered through `st_wr` for one cycle in the second cycle after acceptance. That cycle also carries the mailbox number on `st_mb` and the held frame fields.
- R3: Standard frames compare identifier bits 10:0 only. Extended frames compare bits 28:0. A frame whose format differs from a mailbox's format bit never matches it.
- R4: A compared bit is don't-care when it is 1 in either the mailbox's own mask word (address 64+n) or the shared mask word (word 4). Mailbox identifiers sit at address 32+n, in bits 28:0.
- R5: When several receive mailboxes match, the highest-numbered one is chosen.
- R6: Storing a frame sets that mailbox's pending bit (word 5).
- R7: If the matching mailbox that is highest in number is already pending, its lost bit (word 6) is set. A pending mailbox without protection (word 2) is overwritten, and its lost bit is also set.
- R8: A pending, protected mailbox is skipped and the next lower matching mailbox is used. If every match is blocked, nothing is stored and only the lost bit of the highest match is set.
- R9: A remote frame that matches an enabled transmit mailbox (direction 0) sets that mailbox's remote-pending bit (word 7). It pulses `reply_req` for one cycle with the mailbox on `reply_mb` and stores nothing. A remote frame with no transmit match follows the receive path.
- R10: Writing 1 to bits of words 5, 6 or 7 clears them. Zero bits leave their flags unchanged. A hardware set in the same cycle as a clear wins.
- R11: A frame that matches no mailbox is dropped and changes no status bit.
- R12: A mailbox whose enable bit is 0 never matches.
- R13: Every configuration word reads back the value last written, over its implemented bits.
- R14: After an accepted frame, `frm_ready` stays low for exactly two cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | Frame descriptor valid |
| frm_ready | output | 1 | Filter idle, descriptor accepted this cycle |
| frm_id | input | 29 | Frame identifier (standard in bits 10:0) |
| frm_ide | input | 1 | 1 = extended format |
| frm_rtr | input | 1 | 1 = remote frame |
| frm_dlc | input | 4 | Data length code |
| frm_data | input | 64 | Data bytes |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| st_wr | output | 1 | Mailbox store strobe |
| st_mb | output | 5 | Target mailbox |
| st_id | output | 29 | Stored identifier |
| st_ide | output | 1 | Stored format flag |
| st_rtr | output | 1 | Stored remote flag |
| st_dlc | output | 4 | Stored length code |
| st_data | output | 64 | Stored data bytes |
| reply_req | output | 1 | Automatic reply request |
| reply_mb | output | 5 | Mailbox that should reply |
| pend_o | output | 32 | Receive-pending flags |
| lost_o | output | 32 | Message-lost flags |
| rmtp_o | output | 32 | Remote-pending flags |

## Verification
The assertions check the following on every cycle:
- the strobe lasts one cycle, lands on an enabled receive mailbox and is followed by that mailbox's pending bit;
- a reply request never coincides with a store and always leaves its remote-pending bit set;
- the ready window after acceptance has the stated length;
- a flag falls only under a clear write, and a set always survives a simultaneous clear.

Only the bench scenarios can show which mailbox wins:
- under standard/extended formats, per-mailbox masks and the shared mask;
- when protection skips a mailbox or blocks all of them;
- when a frame is dropped.

The bench's behavioural model predicts every flag and strobe on each clock.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;
    localparam int ID_W   = 29;
    localparam int STD_W  = 11;
    localparam int DLC_W  = 4;
    localparam int DATA_W = 64;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 7;

    localparam logic [ADDR_W-1:0] A_EN   = 7'd0;
    localparam logic [ADDR_W-1:0] A_DIR  = 7'd1;
    localparam logic [ADDR_W-1:0] A_PROT = 7'd2;
    localparam logic [ADDR_W-1:0] A_FMT  = 7'd3;
    localparam logic [ADDR_W-1:0] A_GMSK = 7'd4;
    localparam logic [ADDR_W-1:0] A_PEND = 7'd5;
    localparam logic [ADDR_W-1:0] A_LOST = 7'd6;
    localparam logic [ADDR_W-1:0] A_RMTP = 7'd7;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MATCH  = 2'd1,
        ST_DECIDE = 2'd2
    } flt_state_e;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic              ide;
        logic              rtr;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
    } can_frame_t;
endpackage

// File: rtl/can_mb_match.sv
module can_mb_match
    import can_filt_pkg::*;
(
    input  logic [ID_W-1:0] frm_id,
    input  logic            frm_ide,
    input  logic [ID_W-1:0] mb_id,
    input  logic [ID_W-1:0] mb_mask,
    input  logic [ID_W-1:0] glb_mask,
    input  logic            mb_ext,
    input  logic            mb_en,
    output logic            hit
);
    localparam logic [ID_W-1:0] STD_SPAN = {{(ID_W-STD_W){1'b0}}, {STD_W{1'b1}}};

    logic [ID_W-1:0] span;
    logic [ID_W-1:0] care;
    logic [ID_W-1:0] diff;

    always_comb begin
        span = frm_ide ? {ID_W{1'b1}} : STD_SPAN;
        care = ~(mb_mask | glb_mask) & span;
        diff = (frm_id ^ mb_id) & care;
        hit  = mb_en && (mb_ext == frm_ide) && (diff == '0);
    end
endmodule

// File: rtl/can_mb_pick.sv
module can_mb_pick #(
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/can_mb_status.sv
module can_mb_status #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_pend,
    input  logic [N-1:0] set_lost,
    input  logic [N-1:0] set_rmtp,
    input  logic [N-1:0] clr_pend,
    input  logic [N-1:0] clr_lost,
    input  logic [N-1:0] clr_rmtp,
    output logic [N-1:0] pend_q,
    output logic [N-1:0] lost_q,
    output logic [N-1:0] rmtp_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            lost_q <= '0;
            rmtp_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_pend) | set_pend;
            lost_q <= (lost_q & ~clr_lost) | set_lost;
            rmtp_q <= (rmtp_q & ~clr_rmtp) | set_rmtp;
        end
    end

    // R10
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pend == '0) |=> (($past(pend_q) & ~pend_q) == '0));
    // R10
    lost_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_lost == '0) |=> (($past(lost_q) & ~lost_q) == '0));
    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_pend != '0) |=> ((pend_q & $past(set_pend)) == $past(set_pend)));
endmodule

// File: rtl/can_rx_filter.sv
module can_rx_filter
    import can_filt_pkg::*;
#(
    parameter int NUM_MB = 32,
    localparam int MB_W  = $clog2(NUM_MB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_valid,
    output logic              frm_ready,
    input  logic [ID_W-1:0]   frm_id,
    input  logic              frm_ide,
    input  logic              frm_rtr,
    input  logic [DLC_W-1:0]  frm_dlc,
    input  logic [DATA_W-1:0] frm_data,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              st_wr,
    output logic [MB_W-1:0]   st_mb,
    output logic [ID_W-1:0]   st_id,
    output logic              st_ide,
    output logic              st_rtr,
    output logic [DLC_W-1:0]  st_dlc,
    output logic [DATA_W-1:0] st_data,
    output logic              reply_req,
    output logic [MB_W-1:0]   reply_mb,
    output logic [NUM_MB-1:0] pend_o,
    output logic [NUM_MB-1:0] lost_o,
    output logic [NUM_MB-1:0] rmtp_o
);
    localparam logic [NUM_MB-1:0] MB_ONE = {{(NUM_MB-1){1'b0}}, 1'b1};

    flt_state_e state_q, state_d;
    can_frame_t frm_q;

    logic [NUM_MB-1:0] en_q, dir_q, prot_q, fmt_q;
    logic [ID_W-1:0]   glb_q;
    logic [ID_W-1:0]   id_q  [NUM_MB];
    logic [ID_W-1:0]   msk_q [NUM_MB];

    logic [NUM_MB-1:0] match_w, rx_hit_q, tx_hit_q, cand_w;
    logic              top_found, win_found, tx_found;
    logic [MB_W-1:0]   top_idx, win_idx, tx_idx;
    logic              rmt_take;

    logic [NUM_MB-1:0] set_pend, set_lost, set_rmtp;
    logic [NUM_MB-1:0] clr_pend, clr_lost, clr_rmtp;

    logic [MB_W-1:0]   widx;
    logic              in_id_win, in_msk_win;

    // register port decode
    assign widx       = reg_addr[MB_W-1:0];
    assign in_id_win  = (reg_addr[6:5] == 2'b01) && (int'(reg_addr[4:0]) < NUM_MB);
    assign in_msk_win = (reg_addr[6:5] == 2'b10) && (int'(reg_addr[4:0]) < NUM_MB);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            dir_q  <= '0;
            prot_q <= '0;
            fmt_q  <= '0;
            glb_q  <= '0;
            for (int i = 0; i < NUM_MB; i++) begin
                id_q[i]  <= '0;
                msk_q[i] <= '0;
            end
        end else if (reg_wr) begin
            if (reg_addr == A_EN)   en_q   <= reg_wdata[NUM_MB-1:0];
            if (reg_addr == A_DIR)  dir_q  <= reg_wdata[NUM_MB-1:0];
            if (reg_addr == A_PROT) prot_q <= reg_wdata[NUM_MB-1:0];
            if (reg_addr == A_FMT)  fmt_q  <= reg_wdata[NUM_MB-1:0];
            if (reg_addr == A_GMSK) glb_q  <= reg_wdata[ID_W-1:0];
            if (in_id_win)          id_q[widx]  <= reg_wdata[ID_W-1:0];
            if (in_msk_win)         msk_q[widx] <= reg_wdata[ID_W-1:0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_EN:    reg_rdata[NUM_MB-1:0] = en_q;
            A_DIR:   reg_rdata[NUM_MB-1:0] = dir_q;
            A_PROT:  reg_rdata[NUM_MB-1:0] = prot_q;
            A_FMT:   reg_rdata[NUM_MB-1:0] = fmt_q;
            A_GMSK:  reg_rdata[ID_W-1:0]   = glb_q;
            A_PEND:  reg_rdata[NUM_MB-1:0] = pend_o;
            A_LOST:  reg_rdata[NUM_MB-1:0] = lost_o;
            A_RMTP:  reg_rdata[NUM_MB-1:0] = rmtp_o;
            default: begin
                if (in_id_win)  reg_rdata[ID_W-1:0] = id_q[widx];
                if (in_msk_win) reg_rdata[ID_W-1:0] = msk_q[widx];
            end
        endcase
    end

    assign clr_pend = (reg_wr && reg_addr == A_PEND) ? reg_wdata[NUM_MB-1:0] : '0;
    assign clr_lost = (reg_wr && reg_addr == A_LOST) ? reg_wdata[NUM_MB-1:0] : '0;
    assign clr_rmtp = (reg_wr && reg_addr == A_RMTP) ? reg_wdata[NUM_MB-1:0] : '0;

    // per-mailbox comparators
    for (genvar g = 0; g < NUM_MB; g++) begin : g_mb
        can_mb_match u_match (
            .frm_id   (frm_q.id),
            .frm_ide  (frm_q.ide),
            .mb_id    (id_q[g]),
            .mb_mask  (msk_q[g]),
            .glb_mask (glb_q),
            .mb_ext   (fmt_q[g]),
            .mb_en    (en_q[g]),
            .hit      (match_w[g])
        );
    end

    // frame holding and hit registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frm_q    <= '0;
            rx_hit_q <= '0;
            tx_hit_q <= '0;
        end else begin
            if (state_q == ST_IDLE && frm_valid)
                frm_q <= '{id: frm_id, ide: frm_ide, rtr: frm_rtr,
                           dlc: frm_dlc, data: frm_data};
            if (state_q == ST_MATCH) begin
                rx_hit_q <= match_w & dir_q;
                tx_hit_q <= match_w & ~dir_q;
            end
        end
    end

    assign cand_w = rx_hit_q & ~(pend_o & prot_q);

    can_mb_pick #(.N(NUM_MB), .IW(MB_W)) u_pick_top (
        .vec(rx_hit_q), .found(top_found), .idx(top_idx));
    can_mb_pick #(.N(NUM_MB), .IW(MB_W)) u_pick_win (
        .vec(cand_w), .found(win_found), .idx(win_idx));
    can_mb_pick #(.N(NUM_MB), .IW(MB_W)) u_pick_tx (
        .vec(tx_hit_q), .found(tx_found), .idx(tx_idx));

    assign rmt_take = frm_q.rtr && tx_found;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (frm_valid) state_d = ST_MATCH;
            ST_MATCH:  state_d = ST_DECIDE;
            ST_DECIDE: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        frm_ready = 1'b0;
        st_wr     = 1'b0;
        reply_req = 1'b0;
        set_pend  = '0;
        set_lost  = '0;
        set_rmtp  = '0;
        unique case (state_q)
            ST_IDLE:  frm_ready = 1'b1;
            ST_MATCH: ;
            ST_DECIDE: begin
                if (rmt_take) begin
                    reply_req = 1'b1;
                    set_rmtp  = MB_ONE << tx_idx;
                end else begin
                    if (top_found && pend_o[top_idx])
                        set_lost = set_lost | (MB_ONE << top_idx);
                    if (win_found) begin
                        st_wr    = 1'b1;
                        set_pend = MB_ONE << win_idx;
                        if (pend_o[win_idx])
                            set_lost = set_lost | (MB_ONE << win_idx);
                    end
                end
            end
            default: ;
        endcase
    end

    assign st_mb    = win_idx;
    assign reply_mb = tx_idx;
    assign st_id    = frm_q.id;
    assign st_ide   = frm_q.ide;
    assign st_rtr   = frm_q.rtr;
    assign st_dlc   = frm_q.dlc;
    assign st_data  = frm_q.data;

    can_mb_status #(.N(NUM_MB)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_pend (set_pend),
        .set_lost (set_lost),
        .set_rmtp (set_rmtp),
        .clr_pend (clr_pend),
        .clr_lost (clr_lost),
        .clr_rmtp (clr_rmtp),
        .pend_q   (pend_o),
        .lost_q   (lost_o),
        .rmtp_q   (rmtp_o)
    );

    // R2
    store_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr |-> (en_q[st_mb] && dir_q[st_mb]));
    // R6
    store_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr |=> pend_o[$past(st_mb)]);
    // R14
    store_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr |=> (!st_wr && frm_ready));
    // R9
    reply_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reply_req |-> !st_wr);
    // R9
    reply_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reply_req |=> rmtp_o[$past(reply_mb)]);
    // R14
    busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && frm_ready) |=> !frm_ready ##1 !frm_ready);
endmodule

// File: tb/can_rx_filter_bench.sv
`timescale 1ns/1ps
module can_rx_filter_bench;
    import can_filt_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frm_valid = 1'b0;
    logic              frm_ready;
    logic [28:0]       frm_id = '0;
    logic              frm_ide = 1'b0;
    logic              frm_rtr = 1'b0;
    logic [3:0]        frm_dlc = '0;
    logic [63:0]       frm_data = '0;
    logic              reg_wr = 1'b0;
    logic [6:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              st_wr;
    logic [4:0]        st_mb;
    logic [28:0]       st_id;
    logic              st_ide, st_rtr;
    logic [3:0]        st_dlc;
    logic [63:0]       st_data;
    logic              reply_req;
    logic [4:0]        reply_mb;
    logic [31:0]       pend_o, lost_o, rmtp_o;

    always #4 clk = ~clk;

    can_rx_filter u_can_rx_filter (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ready(frm_ready),
        .frm_id(frm_id), .frm_ide(frm_ide), .frm_rtr(frm_rtr), .frm_dlc(frm_dlc),
        .frm_data(frm_data), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .st_wr(st_wr), .st_mb(st_mb),
        .st_id(st_id), .st_ide(st_ide), .st_rtr(st_rtr), .st_dlc(st_dlc),
        .st_data(st_data), .reply_req(reply_req), .reply_mb(reply_mb),
        .pend_o(pend_o), .lost_o(lost_o), .rmtp_o(rmtp_o)
    );

    int n_vec = 0;
    int n_fail = 0;
    int n_str = 0;
    int n_rep = 0;
    int last_mb = -1;
    bit done = 0;

    // reference model state
    int          phase;
    logic [31:0] m_en, m_dir, m_prot, m_fmt;
    logic [28:0] m_glb;
    logic [28:0] m_id  [32];
    logic [28:0] m_msk [32];
    logic [31:0] e_pend, e_lost, e_rmtp, p_pend, p_lost, p_rmtp;
    logic        e_wr, e_rep;
    int          e_mb, e_rmb, top, win;
    logic [28:0] f_id;
    logic        f_ide, f_rtr;
    logic [63:0] f_data;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic mm(input int n, input logic want_rx);
        int w;
        if (!m_en[n] || m_dir[n] != want_rx || m_fmt[n] != f_ide) return 1'b0;
        w = f_ide ? 29 : 11;
        for (int b = 0; b < w; b++)
            if (!m_msk[n][b] && !m_glb[b] && (f_id[b] != m_id[n][b])) return 1'b0;
        return 1'b1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            phase = 0; e_wr = 0; e_rep = 0; e_mb = 0; e_rmb = 0;
            m_en = 0; m_dir = 0; m_prot = 0; m_fmt = 0; m_glb = 0;
            e_pend = 0; e_lost = 0; e_rmtp = 0; p_pend = 0; p_lost = 0; p_rmtp = 0;
            for (int i = 0; i < 32; i++) begin m_id[i] = 0; m_msk[i] = 0; end
        end else begin
            if (reg_wr) begin
                if (reg_addr == 0) m_en = reg_wdata;
                else if (reg_addr == 1) m_dir = reg_wdata;
                else if (reg_addr == 2) m_prot = reg_wdata;
                else if (reg_addr == 3) m_fmt = reg_wdata;
                else if (reg_addr == 4) m_glb = reg_wdata[28:0];
                else if (reg_addr == 5) e_pend = e_pend & ~reg_wdata;
                else if (reg_addr == 6) e_lost = e_lost & ~reg_wdata;
                else if (reg_addr == 7) e_rmtp = e_rmtp & ~reg_wdata;
                else if (reg_addr >= 32 && reg_addr < 64) m_id[reg_addr-32] = reg_wdata[28:0];
                else if (reg_addr >= 64 && reg_addr < 96) m_msk[reg_addr-64] = reg_wdata[28:0];
            end
            if (phase == 2) begin
                e_pend = e_pend | p_pend;
                e_lost = e_lost | p_lost;
                e_rmtp = e_rmtp | p_rmtp;
                e_wr = 0; e_rep = 0; phase = 0;
            end else if (phase == 1) begin
                p_pend = 0; p_lost = 0; p_rmtp = 0; top = -1; win = -1;
                if (f_rtr)
                    for (int n = 31; n >= 0; n--)
                        if (mm(n, 1'b0)) begin e_rep = 1; e_rmb = n; p_rmtp[n] = 1; break; end
                if (!e_rep) begin
                    for (int n = 31; n >= 0; n--)
                        if (mm(n, 1'b1)) begin
                            if (top < 0) top = n;
                            if (!(e_pend[n] && m_prot[n])) begin win = n; break; end
                        end
                    if (top >= 0 && e_pend[top]) p_lost[top] = 1;
                    if (win >= 0) begin
                        e_wr = 1; e_mb = win; p_pend[win] = 1;
                        if (e_pend[win]) p_lost[win] = 1;
                    end
                end
                phase = 2;
            end else if (frm_valid) begin
                f_id = frm_id; f_ide = frm_ide; f_rtr = frm_rtr; f_data = frm_data;
                phase = 1;
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R14 ready", frm_ready, phase == 0);
            chk("R2 strobe", st_wr, e_wr);
            if (e_wr) begin
                chk("R2 mailbox", st_mb, e_mb);
                chk("R2 data", st_data, f_data);
                chk("R2 id", st_id, f_id);
            end
            chk("R9 reply", reply_req, e_rep);
            if (e_rep) chk("R9 reply mailbox", reply_mb, e_rmb);
            chk("R6 pending", pend_o, e_pend);
            chk("R7 lost", lost_o, e_lost);
            chk("R9 remote pending", rmtp_o, e_rmtp);
            if (st_wr) begin n_str++; last_mb = st_mb; end
            if (reply_req) n_rep++;
        end
    end

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rdchk(input logic [6:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); reg_addr = a; #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic send(input logic [28:0] id, input logic ide, input logic rtr,
                        input logic [31:0] clr_bits);
        @(negedge clk);
        frm_valid = 1; frm_id = id; frm_ide = ide; frm_rtr = rtr;
        frm_dlc = 4'd8; frm_data = {id, 3'b101, id, 3'b010} ^ 64'h5A5A_0F0F_3C3C_9696;
        @(negedge clk); frm_valid = 0;
        if (clr_bits != 0) begin
            @(negedge clk); reg_wr = 1; reg_addr = 7'd5; reg_wdata = clr_bits;
            @(negedge clk); reg_wr = 0;
            repeat (2) @(negedge clk);
        end else
            repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        int s0;
        logic [31:0] sp, sl, sr;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pending", pend_o, 0);
        chk("R1 ready", frm_ready, 1);
        chk("R1 strobe", st_wr, 0);
        rdchk(7'd5, 32'h0, "R1 pending word");

        wr(7'd0, 32'h8000_0460);           // enable 31,10,6,5
        wr(7'd1, 32'h8000_1060);           // receive 31,12,6,5; 10 transmit
        wr(7'd3, 32'h8000_0000);           // 31 extended
        wr(7'd2, 32'h0000_0040);           // protect 6
        wr(7'd32 + 7'd31, 32'h0123_4567);
        wr(7'd32 + 7'd5,  32'h123);
        wr(7'd32 + 7'd6,  32'h120);
        wr(7'd64 + 7'd6,  32'hF);
        wr(7'd32 + 7'd10, 32'h300);
        wr(7'd32 + 7'd12, 32'h055);
        // R13 readback
        rdchk(7'd0, 32'h8000_0460, "R13 enable word");
        rdchk(7'd32 + 7'd31, 32'h0123_4567, "R13 id word");
        rdchk(7'd64 + 7'd6, 32'hF, "R13 mask word");

        // R2/R3 extended match
        send(29'h123_4567, 1, 0, 0);
        chk("R3 extended store", last_mb, 31);
        s0 = n_str;
        send(29'h567, 0, 0, 0);
        chk("R3 format mismatch", n_str - s0, 0);
        send(29'h123, 1, 0, 0);
        chk("R3 ext frame vs std mailbox", n_str - s0, 0);

        // R5 highest wins
        send(29'h123, 0, 0, 0);
        chk("R5 winner", last_mb, 6);
        // R8 protected skip
        send(29'h123, 0, 0, 0);
        chk("R8 skip to lower", last_mb, 5);
        chk("R8 lost on blocked", lost_o[6], 1);
        // R7 overwrite
        send(29'h123, 0, 0, 0);
        chk("R7 overwrite target", last_mb, 5);
        chk("R7 lost on overwrite", lost_o[5], 1);

        // R10 clear
        wr(7'd5, 32'h8000_0060);
        wr(7'd6, 32'h0000_0060);
        chk("R10 pending cleared", pend_o, 0);
        chk("R10 lost cleared", lost_o, 0);

        // R4 shared mask
        wr(7'd4, 32'h100);
        send(29'h023, 0, 0, 0);
        chk("R4 shared mask", last_mb, 6);
        wr(7'd4, 32'h0);
        wr(7'd5, 32'h40);
        // R4 per-mailbox mask
        send(29'h12A, 0, 0, 0);
        chk("R4 mailbox mask", last_mb, 6);

        // R9 remote to transmit mailbox
        s0 = n_str;
        send(29'h300, 0, 1, 0);
        chk("R9 reply count", n_rep, 1);
        chk("R9 no store", n_str - s0, 0);
        chk("R9 remote pending bit", rmtp_o[10], 1);
        // R8 every match blocked
        send(29'h12A, 0, 1, 0);
        chk("R8 all blocked no store", n_str - s0, 0);
        chk("R8 all blocked lost", lost_o[6], 1);
        // R9 remote without transmit match goes to receive
        wr(7'd5, 32'h40);
        send(29'h123, 0, 1, 0);
        chk("R9 remote to receive", last_mb, 6);

        // R11 / R12 drops
        sp = pend_o; sl = lost_o; sr = rmtp_o; s0 = n_str;
        send(29'h7FF, 0, 0, 0);
        chk("R11 no store", n_str - s0, 0);
        chk("R11 pending unchanged", pend_o, sp);
        chk("R11 lost unchanged", lost_o, sl);
        chk("R11 remote unchanged", rmtp_o, sr);
        send(29'h055, 0, 0, 0);
        chk("R12 disabled mailbox", n_str - s0, 0);

        wr(7'd7, 32'h400);
        chk("R10 remote cleared", rmtp_o, 0);

        // R10 set beats simultaneous clear
        wr(7'd5, 32'h40);
        send(29'h12A, 0, 0, 32'h40);
        chk("R10 set wins", pend_o[6], 1);

        repeat (2) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule